// File: doc/BRIEF.md
# Log-Depth Priority Multiplexer

A combinational selector with a parameterized number of input groups, each made of an enable bit and a data word. Group 0 has the highest priority. The output carries the data word of the lowest-numbered group whose enable is set. When no enable is set, the output is zero.

The selection is built as a balanced binary tree of 2-to-1 stages rather than a serial chain. At every node, the higher-priority half wins whenever any enable inside it is set. Each node passes the OR of its two halves' enables up to its parent. The depth is therefore log2 of the group count. The OR at the root also drives a valid flag.

The block is meant to sit in front of a register that the surrounding logic owns. It has no clock and no state.

Top module: `prio_mux_tree`

## Requirements
- R1: When one or more enables are set, `data_o` equals `data_i[k]`, where k is the lowest index with `en_i[k]` = 1. Index 0 is the highest priority.
- R2: When `en_i` is all zero, `data_o` is all zero and `valid_o` is 0.
- R3: `valid_o` equals the OR of all bits of `en_i`.
- R4: While `en_i[k]` is the lowest set enable, the data words of higher-indexed groups (whether enabled or not) have no effect on `data_o`.
- R5: The data word of a group whose enable is 0 never reaches `data_o`. Changing it leaves `data_o` unchanged.
- R6: If any enable in indices 0 to NUM_IN/2-1 is set, `data_o` comes from that upper half, whatever the lower half holds.
- R7: `NUM_IN` must be a power of two (default 8). The behaviour above holds for `NUM_IN` = 4 and `NUM_IN` = 8 across every enable pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| en_i | input | NUM_IN | Per-group enable; bit 0 has the highest priority |
| data_i | input | NUM_IN x DATA_W | Per-group data words, packed, group k at [k] |
| data_o | output | DATA_W | Selected data word, or zero when idle |
| valid_o | output | 1 | Set when any enable is set |

## Verification
The embedded assertions check the following on every evaluation:
- the valid flag equals the OR of the enables (R3);
- the idle case gives a zero output (R2);
- a set enable 0 always wins (R1);
- a single set enable selects its own word (R1).

The full first-set-bit rule can only be shown by the bench's scenarios. They sweep every enable pattern for 4 and 8 groups against a behavioural scan, and they perturb the data of lower-priority and disabled groups while the winner is held. This covers the ignore rules (R4, R5) and the half-selection rule (R6).

// File: rtl/pmux_pkg.sv
package pmux_pkg;
  function automatic int tree_levels(input int n);
    int l = 0;
    while ((1 << l) < n) l++;
    return l;
  endfunction
endpackage

// File: rtl/pmux_leaf.sv
module pmux_leaf #(
  parameter int DATA_W = 8
) (
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              en_o,
  output logic [DATA_W-1:0] data_o
);
  // masking here makes an all-idle tree resolve to zero
  assign en_o   = en_i;
  assign data_o = en_i ? data_i : '0;
endmodule

// File: rtl/pmux_node.sv
module pmux_node #(
  parameter int DATA_W = 8
) (
  input  logic              hi_en_i,
  input  logic [DATA_W-1:0] hi_data_i,
  input  logic              lo_en_i,
  input  logic [DATA_W-1:0] lo_data_i,
  output logic              en_o,
  output logic [DATA_W-1:0] data_o
);
  assign en_o   = hi_en_i | lo_en_i;
  assign data_o = hi_en_i ? hi_data_i : lo_data_i;
endmodule

// File: rtl/prio_mux_tree.sv
module prio_mux_tree
  import pmux_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int DATA_W = 8
) (
  input  logic [NUM_IN-1:0]             en_i,
  input  logic [NUM_IN-1:0][DATA_W-1:0] data_i,
  output logic [DATA_W-1:0]             data_o,
  output logic                          valid_o
);
  localparam int LVL  = tree_levels(NUM_IN);
  localparam int SPAN = 1 << LVL;
  localparam int NODES = 2 * NUM_IN;

  if (SPAN != NUM_IN) begin : g_bad_param
    $error("prio_mux_tree: NUM_IN must be a power of two");
  end

  // heap layout: root at 1, children of k at 2k (higher prio) and 2k+1
  logic              nd_en  [1:NODES-1];
  logic [DATA_W-1:0] nd_dat [1:NODES-1];

  for (genvar i = 0; i < NUM_IN; i++) begin : g_leaf
    pmux_leaf #(.DATA_W(DATA_W)) u_leaf (
      .en_i  (en_i[i]),
      .data_i(data_i[i]),
      .en_o  (nd_en[NUM_IN+i]),
      .data_o(nd_dat[NUM_IN+i])
    );
  end

  for (genvar k = 1; k < NUM_IN; k++) begin : g_node
    pmux_node #(.DATA_W(DATA_W)) u_node (
      .hi_en_i  (nd_en[2*k]),
      .hi_data_i(nd_dat[2*k]),
      .lo_en_i  (nd_en[2*k+1]),
      .lo_data_i(nd_dat[2*k+1]),
      .en_o     (nd_en[k]),
      .data_o   (nd_dat[k])
    );
  end

  assign data_o  = nd_dat[1];
  assign valid_o = nd_en[1];

  always_comb begin
    if (!$isunknown(en_i) && !$isunknown(data_i)) begin
      // R3
      valid_or_chk: assert (valid_o == (|en_i))
        else $error("valid_o mismatch");
      // R2
      idle_zero_chk: assert ((|en_i) || (data_o == '0 && !valid_o))
        else $error("idle output not zero");
      // R1
      top_prio_chk: assert (!en_i[0] || data_o == data_i[0])
        else $error("group 0 did not win");
      // R1
      for (int i = 0; i < NUM_IN; i++) begin
        onehot_sel_chk: assert (!($onehot(en_i) && en_i[i]) || data_o == data_i[i])
          else $error("single enable did not select its word");
      end
    end
  end
endmodule

// File: tb/prio_mux_tree_tb.sv
module prio_mux_tree_tb;
  localparam int DW = 8;

  logic clk = 0;
  logic rst_ni = 0;
  always #4 clk = ~clk;  // 125 MHz

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [3:0]         en4;
  logic [3:0][DW-1:0] d4;
  logic [DW-1:0]      q4;
  logic               v4;
  logic [7:0]         en8;
  logic [7:0][DW-1:0] d8;
  logic [DW-1:0]      q8;
  logic               v8;

  prio_mux_tree #(.NUM_IN(4), .DATA_W(DW)) u_dut4 (
    .en_i(en4), .data_i(d4), .data_o(q4), .valid_o(v4));
  prio_mux_tree #(.NUM_IN(8), .DATA_W(DW)) u_dut (
    .en_i(en8), .data_i(d8), .data_o(q8), .valid_o(v8));

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // behavioural reference: linear scan for first set bit
  function automatic logic [DW+1-1:0] ref8(input logic [7:0] e, input logic [7:0][DW-1:0] d);
    for (int i = 0; i < 8; i++) if (e[i]) return {1'b1, d[i]};
    return '0;
  endfunction
  function automatic logic [DW+1-1:0] ref4(input logic [3:0] e, input logic [3:0][DW-1:0] d);
    for (int i = 0; i < 4; i++) if (e[i]) return {1'b1, d[i]};
    return '0;
  endfunction

  task automatic cmp_all(input string tag);
    logic [DW:0] r4, r8;
    r4 = ref4(en4, d4);
    r8 = ref8(en8, d8);
    chk({tag, " R1/R7 n4 data"}, q4, r4[DW-1:0]);
    chk({tag, " R3 n4 valid"}, {{(DW-1){1'b0}}, v4}, {{(DW-1){1'b0}}, r4[DW]});
    chk({tag, " R1/R7 n8 data"}, q8, r8[DW-1:0]);
    chk({tag, " R3 n8 valid"}, {{(DW-1){1'b0}}, v8}, {{(DW-1){1'b0}}, r8[DW]});
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    en4 = '0; d4 = '0; en8 = '0; d8 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: idle state while held in reset
    chk("R2 reset idle n8 data", q8, '0);
    chk("R2 reset idle n8 valid", {7'd0, v8}, 8'd0);
    rst_ni = 1;

    // R2: idle with nonzero data
    @(posedge clk);
    for (int i = 0; i < 8; i++) d8[i] = 8'hA5 ^ 8'(i);
    for (int i = 0; i < 4; i++) d4[i] = 8'h3C ^ 8'(i);
    @(negedge clk);
    chk("R2 idle n8 zero", q8, '0);
    chk("R2 idle n4 zero", q4, '0);

    // R1/R3/R7: every enable pattern, data varying with pattern
    for (int p = 0; p < 256; p++) begin
      @(posedge clk);
      en8 = 8'(p);
      en4 = 4'(p);
      for (int i = 0; i < 8; i++) d8[i] = 8'(p * 7 + i * 29 + 3);
      for (int i = 0; i < 4; i++) d4[i] = 8'(p * 13 + i * 41 + 1);
      @(negedge clk);
      cmp_all("sweep");
    end

    // R4: winner at index 2, scramble data of lower-priority groups
    @(posedge clk);
    en8 = 8'b1011_0100;
    for (int i = 0; i < 8; i++) d8[i] = 8'h10 + 8'(i);
    @(negedge clk);
    chk("R4 base", q8, 8'h12);
    for (int s = 0; s < 4; s++) begin
      @(posedge clk);
      for (int i = 3; i < 8; i++) d8[i] = 8'(s * 53 + i * 11 + 7);
      @(negedge clk);
      chk("R4 lower data ignored", q8, 8'h12);
    end

    // R5: disabled groups' data changes, output stays
    @(posedge clk);
    en8 = 8'b0100_0000;
    d8[6] = 8'h66;
    @(negedge clk);
    chk("R5 base", q8, 8'h66);
    for (int s = 0; s < 4; s++) begin
      @(posedge clk);
      for (int i = 0; i < 8; i++) if (i != 6) d8[i] = 8'(s * 97 + i * 5 + 1);
      @(negedge clk);
      chk("R5 disabled data ignored", q8, 8'h66);
    end

    // R6: upper half has index 3 set, lower half fully enabled
    @(posedge clk);
    en8 = 8'b1111_1000;
    for (int i = 0; i < 8; i++) d8[i] = 8'hE0 + 8'(i);
    @(negedge clk);
    chk("R6 upper half wins", q8, 8'hE3);
    @(posedge clk);
    en8 = 8'b1111_0000;
    @(negedge clk);
    chk("R6 lower half when upper idle", q8, 8'hE4);

    // R1: lowest priority alone
    @(posedge clk);
    en8 = 8'b1000_0000;
    en4 = 4'b1000;
    d4[3] = 8'h5A;
    @(negedge clk);
    chk("R1 last group n8", q8, 8'hE7);
    chk("R1 last group n4", q4, 8'h5A);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule